// File: doc/BRIEF.md
# FIFO Level, Status and Interrupt Unit

This block keeps the bookkeeping around the transmit and receive FIFOs of a serial controller, but not the FIFO storage itself. It counts how many entries each FIFO holds. Software writes into the transmit FIFO and reads from the receive FIFO over a simple register port. The serial engine drains the transmit FIFO and fills the receive FIFO through single-cycle strobes. For every such access the block reports at once whether it is accepted. The accept strobes tell the storage and the engine whether to move data.

On top of the two counters the block provides a five-bit status word, four threshold registers, a DMA enable register and an interrupt unit. The interrupt unit has raw, mask and masked views and a clear register. Three of the interrupt sources are sticky error flags: a write to a full transmit FIFO, a read from an empty receive FIFO, and an engine push into a full receive FIFO. The other two are level conditions that compare a FIFO count with a threshold. Threshold registers hold only enough bits to count below the FIFO depth, so a driver can find the depth by writing a large value and reading it back.

The register port uses 4-bit word addresses and 16-bit data. Reads are combinational and take effect in the cycle they are presented; writes take effect at the clock edge. Unused read bits and unmapped addresses return zero. Writes to read-only addresses are ignored.

Top module: `fifo_stat_irq`

## Requirements
- R1: The transmit count starts at 0. A write to address 0xC raises it by one unless it equals DEPTH. An `eng_tx_pop` lowers it by one unless it is 0. Both may happen in the same cycle. `tx_push_ok` and `tx_pop_ok` show in the same cycle whether each request is accepted, and the count reads at address 0x2.
- R2: The receive count starts at 0. An `eng_rx_push` raises it by one unless it equals DEPTH. A read of address 0xD lowers it by one unless it is 0. `rx_push_ok` and `rx_pop_ok` show acceptance in the same cycle, and the count reads at address 0x3.
- R3: The status word at address 0x4 holds the following bits: bit 0 is the `eng_busy` input, bit 1 is transmit count equal to DEPTH, bit 2 is transmit count equal to 0, bit 3 is receive count equal to 0, and bit 4 is receive count equal to DEPTH.
- R4: The threshold registers keep only the low log2(DEPTH) bits of the written data, so writing DEPTH reads back 0. The registers are: transmit threshold at 0x0, receive threshold at 0x1, transmit DMA level at 0xA and receive DMA level at 0xB.
- R5: The raw interrupt word at address 0x7 has level-type bits. Bit 0 is 1 while the transmit count is at or below the transmit threshold. Bit 4 is 1 while the receive count is above the receive threshold.
- R6: A write to 0xC while the transmit count equals DEPTH sets raw bit 1 and leaves the count unchanged. An engine push while the receive count equals DEPTH sets raw bit 3. Both bits stay set until cleared.
- R7: A read of 0xD while the receive count is 0 sets raw bit 2, which stays set until cleared.
- R8: A write to the clear register at 0x8 acts on the sticky bits only. Data bit 0 clears all three sticky bits, bit 1 clears raw bit 2, bit 2 clears raw bit 3, and bit 3 clears raw bit 1. An error occurring in the same cycle as its clear leaves the bit set.
- R9: The mask register at 0x5 (5 bits) and the masked word at 0x6 both reset to 0. The masked word equals raw AND mask, and `irq` is 1 exactly when the masked word is non-zero.
- R10: The DMA enable register at 0x9 has bit 0 for receive and bit 1 for transmit. `tx_dma_req` is 1 when transmit is enabled and the transmit count is at or below the transmit DMA level. `rx_dma_req` is 1 when receive is enabled and the receive count is above the receive DMA level.
- R11: After reset, every register and sticky bit is 0, `irq` is 0 and both DMA requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| eng_busy | input | 1 | Serial engine busy, shown in status bit 0 |
| eng_tx_pop | input | 1 | Engine takes one entry from the transmit FIFO |
| eng_rx_push | input | 1 | Engine places one entry into the receive FIFO |
| tx_push_ok | output | 1 | Software transmit write accepted this cycle |
| tx_pop_ok | output | 1 | Engine transmit pop accepted this cycle |
| rx_push_ok | output | 1 | Engine receive push accepted this cycle |
| rx_pop_ok | output | 1 | Software receive read accepted this cycle |
| irq | output | 1 | OR of the masked interrupt bits |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest cases to reach from the ports occur at the full boundary. One is a push and a pop arriving together when a count sits at DEPTH. The other is an overflow on the same edge as a clear of that overflow. Reaching either one requires DEPTH uninterrupted fills first. Directed sequences fill each FIFO to DEPTH and then strike these edges on purpose. The random phase runs in segments that favour filling, draining, receiving and reading in turn, so both counters sweep through empty and full many times while clears, mask changes and threshold writes arrive at random moments.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
    localparam int ADDR_W = 4;
    localparam int REG_W  = 16;
    localparam int NSRC   = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_TXTHR   = 4'h0,
        A_RXTHR   = 4'h1,
        A_TXLVL   = 4'h2,
        A_RXLVL   = 4'h3,
        A_STAT    = 4'h4,
        A_IMASK   = 4'h5,
        A_IMSKD   = 4'h6,
        A_IRAW    = 4'h7,
        A_ICLR    = 4'h8,
        A_DMAEN   = 4'h9,
        A_TXDMA   = 4'hA,
        A_RXDMA   = 4'hB,
        A_TXDATA  = 4'hC,
        A_RXDATA  = 4'hD
    } reg_addr_e;

    // interrupt source positions
    localparam int S_TXE = 0;
    localparam int S_TXO = 1;
    localparam int S_RXU = 2;
    localparam int S_RXO = 3;
    localparam int S_RXF = 4;
endpackage

// File: rtl/fsi_level_ctr.sv
module fsi_level_ctr #(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_req,
    input  logic             dec_req,
    output logic             inc_ok,
    output logic             dec_ok,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    assign full   = (level == TOP);
    assign empty  = (level == '0);
    assign inc_ok = inc_req && !full;
    assign dec_ok = dec_req && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case ({inc_ok, dec_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP) else $error("level above depth");                      // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && inc_req && !dec_req) |=> full) else $error("full lost");    // R2
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && dec_req && !inc_req) |=> empty) else $error("empty lost"); // R2
endmodule

// File: rtl/fsi_irq.sv
module fsi_irq import fsi_pkg::*; (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_txo,
    input  logic            set_rxu,
    input  logic            set_rxo,
    input  logic            clr_wr,
    input  logic [3:0]      clr_bits,
    input  logic            lvl_txe,
    input  logic            lvl_rxf,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] masked,
    output logic            irq
);
    // sticky index: 0 rx underflow, 1 rx overflow, 2 tx overflow;
    // the per-source clear bit for sticky k is clr_bits[k+1]
    logic [2:0] stk;
    logic [2:0] set_v;
    assign set_v = {set_txo, set_rxo, set_rxu};

    for (genvar k = 0; k < 3; k++) begin : g_stk
        logic clr_k;
        assign clr_k = clr_wr && (clr_bits[0] || clr_bits[k+1]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stk[k] <= 1'b0;
            else if (set_v[k])   stk[k] <= 1'b1;
            else if (clr_k)      stk[k] <= 1'b0;
        end

        AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (stk[k] && !clr_k) |=> stk[k]) else $error("sticky dropped");          // R6
        AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_k && !set_v[k]) |=> !stk[k]) else $error("clear ignored");         // R8
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_v[k] |=> stk[k]) else $error("set lost");                           // R8
    end

    assign raw    = {lvl_rxf, stk[1], stk[0], stk[2], lvl_txe};
    assign masked = raw & mask;
    assign irq    = |masked;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq) else $error("irq with zero mask");                   // R9
endmodule

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq import fsi_pkg::*; #(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    output logic              tx_push_ok,
    output logic              tx_pop_ok,
    output logic              rx_push_ok,
    output logic              rx_pop_ok,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int THR_W = $clog2(DEPTH);
    localparam int TX = 0;
    localparam int RX = 1;

    reg_addr_e addr_e;
    assign addr_e = reg_addr_e'(bus_addr);

    logic tx_wr_req, rx_rd_req, clr_wr;
    assign tx_wr_req = bus_wr && (addr_e == A_TXDATA);
    assign rx_rd_req = bus_rd && (addr_e == A_RXDATA);
    assign clr_wr    = bus_wr && (addr_e == A_ICLR);

    // ---- level counters, index 0 = transmit, 1 = receive ----
    logic [1:0]       inc_req, dec_req, inc_ok, dec_ok, full, empty;
    logic [LVL_W-1:0] lvl [2];

    assign inc_req = {eng_rx_push, tx_wr_req};
    assign dec_req = {rx_rd_req, eng_tx_pop};

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        fsi_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_req (inc_req[g]),
            .dec_req (dec_req[g]),
            .inc_ok  (inc_ok[g]),
            .dec_ok  (dec_ok[g]),
            .full    (full[g]),
            .empty   (empty[g]),
            .level   (lvl[g])
        );
    end

    assign tx_push_ok = inc_ok[TX];
    assign tx_pop_ok  = dec_ok[TX];
    assign rx_push_ok = inc_ok[RX];
    assign rx_pop_ok  = dec_ok[RX];

    // ---- programmable registers ----
    logic [THR_W-1:0] tx_thr, rx_thr, tx_dlvl, rx_dlvl;
    logic [NSRC-1:0]  mask;
    logic [1:0]       dma_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr  <= '0;
            rx_thr  <= '0;
            tx_dlvl <= '0;
            rx_dlvl <= '0;
            mask    <= '0;
            dma_en  <= '0;
        end else if (bus_wr) begin
            case (addr_e)
                A_TXTHR: tx_thr  <= bus_wdata[THR_W-1:0];
                A_RXTHR: rx_thr  <= bus_wdata[THR_W-1:0];
                A_TXDMA: tx_dlvl <= bus_wdata[THR_W-1:0];
                A_RXDMA: rx_dlvl <= bus_wdata[THR_W-1:0];
                A_IMASK: mask    <= bus_wdata[NSRC-1:0];
                A_DMAEN: dma_en  <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    // ---- interrupt unit ----
    logic [NSRC-1:0] raw, masked;
    logic            lvl_txe, lvl_rxf;

    assign lvl_txe = lvl[TX] <= LVL_W'(tx_thr);
    assign lvl_rxf = lvl[RX] >  LVL_W'(rx_thr);

    fsi_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_txo  (tx_wr_req && full[TX]),
        .set_rxu  (rx_rd_req && empty[RX]),
        .set_rxo  (eng_rx_push && full[RX]),
        .clr_wr   (clr_wr),
        .clr_bits (bus_wdata[3:0]),
        .lvl_txe  (lvl_txe),
        .lvl_rxf  (lvl_rxf),
        .mask     (mask),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq)
    );

    assign tx_dma_req = dma_en[1] && (lvl[TX] <= LVL_W'(tx_dlvl));
    assign rx_dma_req = dma_en[0] && (lvl[RX] >  LVL_W'(rx_dlvl));

    // ---- read mux ----
    always_comb begin
        bus_rdata = '0;
        case (addr_e)
            A_TXTHR: bus_rdata = REG_W'(tx_thr);
            A_RXTHR: bus_rdata = REG_W'(rx_thr);
            A_TXLVL: bus_rdata = REG_W'(lvl[TX]);
            A_RXLVL: bus_rdata = REG_W'(lvl[RX]);
            A_STAT:  bus_rdata = REG_W'({full[RX], empty[RX], empty[TX], full[TX], eng_busy});
            A_IMASK: bus_rdata = REG_W'(mask);
            A_IMSKD: bus_rdata = REG_W'(masked);
            A_IRAW:  bus_rdata = REG_W'(raw);
            A_DMAEN: bus_rdata = REG_W'(dma_en);
            A_TXDMA: bus_rdata = REG_W'(tx_dlvl);
            A_RXDMA: bus_rdata = REG_W'(rx_dlvl);
            default: bus_rdata = '0;
        endcase
    end

    AST_TXO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && !tx_push_ok) |=> raw[S_TXO]) else $error("tx overflow missed");  // R6
    AST_RXO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && !rx_push_ok) |=> raw[S_RXO]) else $error("rx overflow missed"); // R6
    AST_RXU_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_req && !rx_pop_ok) |=> raw[S_RXU]) else $error("rx underflow missed");  // R7
endmodule

// File: tb/fifo_stat_irq_tb.sv
`timescale 1ns/1ps
module fifo_stat_irq_tb;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic        tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic        irq, tx_dma_req, rx_dma_req;

    always #2 clk = ~clk;

    fifo_stat_irq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok),
        .rx_push_ok(rx_push_ok), .rx_pop_ok(rx_pop_ok),
        .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    int m_tx = 0, m_rx = 0;
    bit m_txo = 0, m_rxu = 0, m_rxo = 0;
    int m_txthr = 0, m_rxthr = 0, m_txd = 0, m_rxd = 0;
    int m_mask = 0, m_den = 0;
    bit m_busy = 0;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int exp_raw();
        return {27'd0, (m_rx > m_rxthr), m_rxo, m_rxu, m_txo, (m_tx <= m_txthr)};
    endfunction

    function automatic int exp_stat();
        return {27'd0, (m_rx == DEPTH), (m_rx == 0), (m_tx == 0), (m_tx == DEPTH), m_busy};
    endfunction

    function automatic int exp_reg(input int a);
        case (a)
            0: return m_txthr;
            1: return m_rxthr;
            2: return m_tx;
            3: return m_rx;
            4: return exp_stat();
            5: return m_mask;
            6: return exp_raw() & m_mask;
            7: return exp_raw();
            9: return m_den;
            10: return m_txd;
            11: return m_rxd;
            default: return 0;
        endcase
    endfunction

    task automatic check_outs();
        chk("R9 irq", int'(irq), int'((exp_raw() & m_mask) != 0));
        chk("R10 tx_dma_req", int'(tx_dma_req), int'(m_den[1] && m_tx <= m_txd));
        chk("R10 rx_dma_req", int'(rx_dma_req), int'(m_den[0] && m_rx > m_rxd));
    endtask

    // one clock cycle of stimulus, checked against the model
    task automatic cyc(input bit wr, input bit rd, input int a, input int wd,
                       input bit pop, input bit push, input bit busy);
        bit txp, rxp;
        int ntx, nrx;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = 4'(a); bus_wdata = 16'(wd);
        eng_tx_pop = pop; eng_rx_push = push; eng_busy = busy;
        #1;
        txp = wr && (a == 12);
        rxp = rd && (a == 13);
        chk("R1 tx_push_ok", int'(tx_push_ok), int'(txp && m_tx < DEPTH));
        chk("R1 tx_pop_ok",  int'(tx_pop_ok),  int'(pop && m_tx > 0));
        chk("R2 rx_push_ok", int'(rx_push_ok), int'(push && m_rx < DEPTH));
        chk("R2 rx_pop_ok",  int'(rx_pop_ok),  int'(rxp && m_rx > 0));
        @(posedge clk);
        if (wr && a == 8) begin
            if (wd[0]) begin m_txo = 0; m_rxu = 0; m_rxo = 0; end
            if (wd[1]) m_rxu = 0;
            if (wd[2]) m_rxo = 0;
            if (wd[3]) m_txo = 0;
        end
        if (txp && m_tx == DEPTH) m_txo = 1;
        if (push && m_rx == DEPTH) m_rxo = 1;
        if (rxp && m_rx == 0) m_rxu = 1;
        ntx = m_tx + int'(txp && m_tx < DEPTH) - int'(pop && m_tx > 0);
        nrx = m_rx + int'(push && m_rx < DEPTH) - int'(rxp && m_rx > 0);
        m_tx = ntx; m_rx = nrx;
        if (wr) begin
            case (a)
                0: m_txthr = wd % DEPTH;
                1: m_rxthr = wd % DEPTH;
                5: m_mask = wd & 31;
                9: m_den = wd & 3;
                10: m_txd = wd % DEPTH;
                11: m_rxd = wd % DEPTH;
                default: ;
            endcase
        end
        m_busy = busy;
        #1;
        bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0;
        check_outs();
    endtask

    task automatic rd_check(input int a, input string req);
        @(negedge clk);
        bus_rd = 1; bus_addr = 4'(a);
        #1;
        chk(req, int'(bus_rdata), exp_reg(a));
        @(posedge clk);
        #1;
        bus_rd = 0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1, 0, a, d, 0, 0, m_busy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int r, seg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        rd_check(2, "R11 tx level after reset");
        rd_check(3, "R11 rx level after reset");
        rd_check(4, "R3 status after reset");
        chk("R3 status literal", int'(bus_rdata), 32'h0C);
        rd_check(7, "R5 raw after reset");
        rd_check(5, "R11 mask after reset");
        rd_check(6, "R9 masked after reset");
        check_outs();
        chk("R11 irq literal", int'(irq), 0);

        // R4 threshold truncation reveals depth
        wr(0, DEPTH);     rd_check(0, "R4 tx threshold of DEPTH");
        chk("R4 tx thr zero", int'(bus_rdata), 0);
        wr(0, DEPTH - 1); rd_check(0, "R4 tx threshold max");
        wr(1, DEPTH + 8); rd_check(1, "R4 rx threshold wrap");
        chk("R4 rx thr 8", int'(bus_rdata), 8);
        wr(10, 3); rd_check(10, "R4 tx dma level");
        wr(11, 70); rd_check(11, "R4 rx dma level");
        wr(0, 4); wr(1, 2);

        // R1, R6 fill transmit FIFO then overflow
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 12, i, 0, 0, 1);
        rd_check(2, "R1 tx level full");
        rd_check(4, "R3 status tx full busy");
        cyc(1, 0, 12, 0, 0, 0, 0);
        rd_check(2, "R6 tx level unchanged on overflow");
        rd_check(7, "R6 tx overflow raw");
        chk("R6 txo bit", int'(bus_rdata[1]), 1);
        // full with push and pop together
        cyc(1, 0, 12, 0, 1, 0, 0);
        rd_check(2, "R1 simultaneous at full");
        // R8 per-source clears
        wr(8, 2); rd_check(7, "R8 wrong clear keeps txo");
        wr(8, 8); rd_check(7, "R8 txo cleared");
        chk("R8 txo zero", int'(bus_rdata[1]), 0);

        // R7 underflow
        cyc(0, 1, 13, 0, 0, 0, 0);
        rd_check(7, "R7 rx underflow raw");
        chk("R7 rxu bit", int'(bus_rdata[2]), 1);
        wr(8, 1); rd_check(7, "R8 clear all");

        // R6 rx overflow, set with clear in same cycle
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        rd_check(3, "R2 rx level full");
        cyc(1, 0, 8, 4, 0, 1, 0);
        rd_check(7, "R8 set wins over clear");
        chk("R8 rxo bit", int'(bus_rdata[3]), 1);
        wr(8, 4); rd_check(7, "R8 rxo cleared");

        // R9 mask
        wr(5, 16); rd_check(6, "R9 masked rx full");
        chk("R9 irq on", int'(irq), 1);
        wr(5, 2); rd_check(6, "R9 masked quiet");

        // R10 dma
        wr(9, 3);
        cyc(0, 1, 13, 0, 1, 0, 0);

        // random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            bit w, rd, pop, push, busy;
            int a, d;
            seg = (i / 250) % 4;
            r = $urandom % 100;
            w = 0; rd = 0; a = 0; d = 0;
            case (seg)
                0: if (r < 70) begin w = 1; a = 12; end else if (r < 75) begin rd = 1; a = 13; end
                1: if (r < 15) begin w = 1; a = 12; end else if (r < 40) begin rd = 1; a = 13; end
                2: if (r < 10) begin rd = 1; a = 13; end else if (r < 30) begin w = 1; a = 12; end
                default: if (r < 60) begin rd = 1; a = 13; end
            endcase
            if (!w && !rd) begin
                r = $urandom % 100;
                d = $urandom % 64;
                if (r < 8)       begin w = 1; a = 8;  d = $urandom % 16; end
                else if (r < 12) begin w = 1; a = 5; end
                else if (r < 16) begin w = 1; a = ($urandom % 2); end
                else if (r < 19) begin w = 1; a = 10 + ($urandom % 2); end
                else if (r < 21) begin w = 1; a = 9; end
            end
            pop  = ($urandom % 100) < ((seg == 1) ? 70 : 20);
            push = ($urandom % 100) < ((seg == 2) ? 75 : (seg == 3 ? 10 : 30));
            busy = $urandom % 2;
            cyc(w, rd, a, d, pop, push, busy);
            if (i % 8 == 7) begin
                int sel;
                sel = $urandom % 5;
                case (sel)
                    0: rd_check(2, "R1 tx level random");
                    1: rd_check(3, "R2 rx level random");
                    2: rd_check(4, "R3 status random");
                    3: rd_check(7, "R5 raw random");
                    default: rd_check(6, "R9 masked random");
                endcase
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule